// File: doc/BRIEF.md
# Platform Interrupt Controller with Programmable Gateways

This block gathers interrupt requests from a set of peripheral sources and presents one external-interrupt line to a single hart context. Each source first passes a gateway. The gateway decides whether the source is edge- or level-signalled and whether it is active high or active low. It then latches a pending bit and keeps one request from that source in flight at a time.

Every source has a priority. The context has one enable bit per source and a priority threshold. Among the sources that are pending and enabled, and whose priority is strictly above the threshold, the block picks a winner. The interrupt line is high whenever such a winner exists.

Software takes the interrupt by reading the claim register. The read returns the winner's ID and clears its pending bit. Software finishes the interrupt by writing the same ID back to that register, which frees the gateway for the next request. The register port is a plain 32-bit word interface: one request cycle, with read data returned one cycle later.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, the enable word, the trigger-type word, the polarity word and the threshold read as zero. The pending word reads zero, `eip_o` is low and a claim read returns 0.
- R2: Byte offsets are as follows. Priority of source n is at 4*n. The pending word is at 0x1000 and the enable word at 0x2000. The trigger-type word is at 0x3000, where bit n = 1 selects edge mode. The polarity word is at 0x3004, where bit n = 1 selects active low. The threshold is at 0x200000 and claim/complete is at 0x200004. Read data appears on `bus_rdata` in the cycle after the request.
- R3: A source whose priority is 0 never raises `eip_o` and is never returned by a claim.
- R4: `eip_o` is high exactly when some source is pending, enabled, and has a priority strictly greater than the threshold.
- R5: A claim read returns the ID of the highest-priority qualifying source, or 0 if there is none, and clears that source's pending bit.
- R6: When several qualifying sources share the top priority, the lowest ID wins.
- R7: After a claim, the claimed source cannot become pending again until its own ID is written to the claim/complete offset. Writing a different ID does not release it.
- R8: In level mode (the reset default), a source whose input is still active when it is completed becomes pending again.
- R9: In edge mode, each inactive-to-active transition sets pending. An input held active does not re-pend after completion.
- R10: With the polarity bit set, a low input is the active state.
- R11: ID 0 is reserved. Its pending bit and enable bit always read 0, its priority reads 0, and `src_i[0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt inputs, one per source ID |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| eip_o | output | 1 | External interrupt request to the hart context |

## Verification
The assertions assume that `src_i` is synchronous to `clk`. They also assume that software completes only IDs it has claimed, and never issues a claim read and a complete write in the same cycle; the single-request port makes that impossible. The bench changes sources only on falling edges and issues one access at a time. It keeps a complete for every claim it makes, and it drains all leftover pending bits between table rows. That drain temporarily raises zero priorities to 1, so that sources which could otherwise never be claimed are cleared.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_PEND,
    SEL_EN,
    SEL_TYPE,
    SEL_POL,
    SEL_THR,
    SEL_CLAIM
  } reg_sel_e;

  localparam logic [31:0] OFF_PEND  = 32'h0000_1000;
  localparam logic [31:0] OFF_EN    = 32'h0000_2000;
  localparam logic [31:0] OFF_TYPE  = 32'h0000_3000;
  localparam logic [31:0] OFF_POL   = 32'h0000_3004;
  localparam logic [31:0] OFF_THR   = 32'h0020_0000;
  localparam logic [31:0] OFF_CLAIM = 32'h0020_0004;

endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic active_low_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o
);

  logic lvl, prev_q, req;
  logic pend_q, pend_d, busy_q, busy_d;

  // normalise polarity, then pick the request form
  assign lvl = src_i ^ active_low_i;
  assign req = edge_mode_i ? (lvl & ~prev_q) : lvl;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else begin
      if (complete_i) busy_d = 1'b0;
      if (!busy_q && !pend_q && req) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      prev_q <= lvl;
    end
  end

  assign pend_o = pend_q;

  // an in-flight source may not re-pend before completion
  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !complete_i) |=> !$rose(pend_q));

  // a claim always leaves the pending bit clear
  p_claim_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> !pend_q);

endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                win_id_o,
  output logic                           win_valid_o
);

  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: ties keep the lower ID
  always_comb begin
    best_p   = thr_i;
    win_id_o = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
        best_p   = prio_i[i];
        win_id_o = ID_W'(i);
      end
    end
  end

  assign win_valid_o = (win_id_o != '0);

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               eip_o
);

  localparam int ID_W = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] ID0_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  reg_sel_e    sel;
  logic [31:0] addr32, word_idx, rdata_d, rdata_q;
  logic [ID_W-1:0] slot;
  logic wr_fire, rd_fire, claim_fire, cmpl_fire;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0] en_q, type_q, pol_q;
  logic [PRIO_W-1:0]  thr_q;
  logic [NUM_SRC-1:0] pend_vec, claim_vec, cmpl_vec;
  logic [ID_W-1:0]    win_id;
  logic               win_valid;

  // ---------------- address decode ----------------
  assign addr32   = 32'(bus_addr);
  assign word_idx = 32'(bus_addr[11:2]);
  assign slot     = bus_addr[ID_W+1:2];

  always_comb begin
    sel = SEL_NONE;
    if (addr32[1:0] == 2'b00) begin
      if (addr32[31:12] == '0 && word_idx < 32'(NUM_SRC)) sel = SEL_PRIO;
      else if (addr32 == OFF_PEND)  sel = SEL_PEND;
      else if (addr32 == OFF_EN)    sel = SEL_EN;
      else if (addr32 == OFF_TYPE)  sel = SEL_TYPE;
      else if (addr32 == OFF_POL)   sel = SEL_POL;
      else if (addr32 == OFF_THR)   sel = SEL_THR;
      else if (addr32 == OFF_CLAIM) sel = SEL_CLAIM;
    end
  end

  assign wr_fire    = bus_req &  bus_we;
  assign rd_fire    = bus_req & ~bus_we;
  assign claim_fire = rd_fire && (sel == SEL_CLAIM);
  assign cmpl_fire  = wr_fire && (sel == SEL_CLAIM) && (bus_wdata < 32'(NUM_SRC));

  // ---------------- configuration registers ----------------
  always_comb begin
    prio_d = prio_q;
    if (slot != '0) prio_d[slot] = bus_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      type_q <= '0;
      pol_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_fire && sel == SEL_PRIO) prio_q <= prio_d;
      if (wr_fire && sel == SEL_EN)   en_q   <= bus_wdata[NUM_SRC-1:0] & ID0_MASK;
      if (wr_fire && sel == SEL_TYPE) type_q <= bus_wdata[NUM_SRC-1:0] & ID0_MASK;
      if (wr_fire && sel == SEL_POL)  pol_q  <= bus_wdata[NUM_SRC-1:0] & ID0_MASK;
      if (wr_fire && sel == SEL_THR)  thr_q  <= bus_wdata[PRIO_W-1:0];
    end
  end

  // ---------------- gateways ----------------
  assign pend_vec[0]  = 1'b0;
  assign claim_vec[0] = 1'b0;
  assign cmpl_vec[0]  = 1'b0;

  for (genvar g = 1; g < NUM_SRC; g++) begin : g_gw
    assign claim_vec[g] = claim_fire && win_valid && (win_id == ID_W'(g));
    assign cmpl_vec[g]  = cmpl_fire && (bus_wdata == 32'(g));

    irq_hub_gateway u_gw (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (src_i[g]),
      .edge_mode_i  (type_q[g]),
      .active_low_i (pol_q[g]),
      .claim_i      (claim_vec[g]),
      .complete_i   (cmpl_vec[g]),
      .pend_o       (pend_vec[g])
    );
  end

  // ---------------- arbitration ----------------
  irq_hub_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i      (pend_vec),
    .en_i        (en_q),
    .prio_i      (prio_q),
    .thr_i       (thr_q),
    .win_id_o    (win_id),
    .win_valid_o (win_valid)
  );

  assign eip_o = win_valid;

  // ---------------- read path ----------------
  always_comb begin
    unique case (sel)
      SEL_PRIO:  rdata_d = 32'(prio_q[slot]);
      SEL_PEND:  rdata_d = 32'(pend_vec);
      SEL_EN:    rdata_d = 32'(en_q);
      SEL_TYPE:  rdata_d = 32'(type_q);
      SEL_POL:   rdata_d = 32'(pol_q);
      SEL_THR:   rdata_d = 32'(thr_q);
      SEL_CLAIM: rdata_d = 32'(win_id);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // ---------------- assertions ----------------
  p_win_qualifies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend_vec[win_id] && en_q[win_id] && (prio_q[win_id] > thr_q)));

  p_zero_prio_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (prio_q[win_id] != '0));

  p_claim_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  p_claim_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vec & ~pend_vec) == '0);

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;

  localparam int NUM_SRC = 32;
  localparam int ADDR_W  = 24;
  localparam logic [23:0] A_PEND  = 24'h001000;
  localparam logic [23:0] A_EN    = 24'h002000;
  localparam logic [23:0] A_TYPE  = 24'h003000;
  localparam logic [23:0] A_POL   = 24'h003004;
  localparam logic [23:0] A_THR   = 24'h200000;
  localparam logic [23:0] A_CLAIM = 24'h200004;

  // row: {src[31:0], en[31:0], thr[2:0], expected id[4:0]}; priority of n is n&7
  localparam int NROW = 8;
  localparam logic [71:0] VEC [NROW] = '{
    {32'h0000_0028, 32'hFFFF_FFFF, 3'd0, 5'd5 },  // R5 highest of 3,5
    {32'h0000_8080, 32'hFFFF_FFFF, 3'd0, 5'd7 },  // R6 tie 7/15
    {32'h0000_0100, 32'hFFFF_FFFF, 3'd0, 5'd0 },  // R3 prio 0
    {32'h0000_0020, 32'hFFFF_FFFF, 3'd5, 5'd0 },  // R4 equal to thr
    {32'h0000_0020, 32'hFFFF_FFFF, 3'd4, 5'd5 },  // R4 above thr
    {32'h0000_0060, 32'h0000_0020, 3'd0, 5'd5 },  // R4 enable gates 6
    {32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 5'd0 },  // R11 source 0
    {32'h8000_0004, 32'hFFFF_FFFF, 3'd0, 5'd31}   // R5 top id
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_SRC-1:0] src;
  logic               bus_req, bus_we;
  logic [ADDR_W-1:0]  bus_addr;
  logic [31:0]        bus_wdata, bus_rdata;
  logic               eip;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  irq_hub #(.NUM_SRC(NUM_SRC), .PRIO_W(3), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eip_o(eip)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drain();
    logic [31:0] id;
    src = '0;
    wr(A_EN, 32'hFFFF_FFFF);
    wr(A_THR, 32'd0);
    for (int i = 8; i < NUM_SRC; i += 8) wr(24'(4 * i), 32'd1);
    for (int k = 0; k < 40; k++) begin
      rd(A_CLAIM, id);
      if (id == 0) break;
      wr(A_CLAIM, id);
    end
    for (int i = 8; i < NUM_SRC; i += 8) wr(24'(4 * i), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 eip", 32'(eip), 0);
    rd(A_PEND, d);       check("R1 pending", d, 0);
    rd(A_EN, d);         check("R1 enable", d, 0);
    rd(A_THR, d);        check("R1 threshold", d, 0);
    rd(24'h000014, d);   check("R1 prio5", d, 0);
    rd(A_CLAIM, d);      check("R1 claim", d, 0);

    // R2 map readback
    wr(A_THR, 32'd3);    rd(A_THR, d);       check("R2 threshold", d, 3);
    wr(24'h000024, 5);   rd(24'h000024, d);  check("R2 prio9", d, 5);
    wr(A_TYPE, 32'h10);  rd(A_TYPE, d);      check("R2 type", d, 32'h10);
    wr(A_TYPE, 0);       wr(A_THR, 0);

    for (int i = 1; i < NUM_SRC; i++) wr(24'(4 * i), 32'(i & 7));

    // table walk
    for (int r = 0; r < NROW; r++) begin
      logic [31:0] vs, ve, exp;
      vs = VEC[r][71:40]; ve = VEC[r][39:8]; exp = 32'(VEC[r][4:0]);
      wr(A_EN, ve);
      wr(A_THR, 32'(VEC[r][7:5]));
      src = vs;
      repeat (2) @(negedge clk);
      check($sformatf("R4 row%0d eip", r), 32'(eip), 32'(exp != 0));
      rd(A_CLAIM, d);
      check($sformatf("R5 R6 R3 R11 row%0d claim", r), d, exp);
      if (d != 0) wr(A_CLAIM, d);
      drain();
    end

    // R5 R7 R8 level mode
    src[3] = 1'b1;
    rd(A_PEND, d);   check("R5 pend set", d, 32'h8);
    rd(A_CLAIM, d);  check("R5 claim id", d, 3);
    rd(A_PEND, d);   check("R7 blocked after claim", d, 0);
    check("R7 eip low", 32'(eip), 0);
    wr(A_CLAIM, 5);
    rd(A_PEND, d);   check("R7 wrong id keeps block", d, 0);
    wr(A_CLAIM, 3);
    rd(A_PEND, d);   check("R8 level re-pend", d, 32'h8);
    src[3] = 1'b0;
    rd(A_CLAIM, d);  check("R8 reclaim", d, 3);
    wr(A_CLAIM, 3);
    rd(A_PEND, d);   check("R8 inactive no re-pend", d, 0);

    // R9 edge mode
    wr(A_TYPE, 32'h10);
    src[4] = 1'b1;
    rd(A_PEND, d);   check("R9 edge pend", d, 32'h10);
    rd(A_CLAIM, d);  check("R9 claim", d, 4);
    wr(A_CLAIM, 4);
    rd(A_PEND, d);   check("R9 held no re-pend", d, 0);
    src[4] = 1'b0; @(negedge clk); src[4] = 1'b1;
    rd(A_PEND, d);   check("R9 new edge", d, 32'h10);
    rd(A_CLAIM, d);  check("R9 claim2", d, 4);
    src[4] = 1'b0; @(negedge clk); src[4] = 1'b1;
    rd(A_PEND, d);   check("R7 edge while busy", d, 0);
    wr(A_CLAIM, 4);
    rd(A_PEND, d);   check("R9 edge not queued", d, 0);
    src[4] = 1'b0;
    wr(A_TYPE, 0);

    // R10 polarity
    wr(A_POL, 32'h40);
    rd(A_PEND, d);   check("R10 low active", d, 32'h40);
    rd(A_CLAIM, d);  check("R10 claim", d, 6);
    src[6] = 1'b1;
    wr(A_CLAIM, 6);
    rd(A_PEND, d);   check("R10 high inactive", d, 0);
    wr(A_POL, 0);
    rd(A_PEND, d);   check("R10 back to active high", d, 32'h40);
    src[6] = 1'b0;
    rd(A_CLAIM, d);  wr(A_CLAIM, d);

    // R11 reserved id
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d);     check("R11 enable bit0", d, 32'hFFFF_FFFE);
    wr(24'h000000, 7);
    rd(24'h000000, d); check("R11 prio0", d, 0);
    src[0] = 1'b1;
    rd(A_PEND, d);   check("R11 pend bit0", d, 0);
    src[0] = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule